// File: doc/BRIEF.md
# Passive Serial Configuration Host Sequencer

This block sits on the host side of a serial configuration link and loads a bitstream into a target device. On a start request it pulls the target's active-low reconfiguration request line low and holds it there for a minimum time. It then checks that the target answers by pulling both its active-low status line and its done line low, and that the status low pulse lasts within a legal window. After that it shifts bytes, taken from a valid/ready stream, out on a serial data pin, least significant bit first, with one serial clock per bit.

Loading ends when the target raises its done line. A stream that ends without done gets a fixed number of extra serial clocks and is then declared timed out. A status drop during loading aborts the run. When the block is not loading, the serial clock and data pins sit at parameterized fixed levels. Every time window is a parameter counted in system clock cycles. The target's status and done inputs pass through a synchronizer, and the cycle counts are taken on the synchronized samples.

Top module: `ps_cfg_host`

## Requirements
- R1: Out of reset and while idle, reconf_no is 1, busy_o, done_o, err_o and in_ready_o are 0, ser_clk_o equals PARK_CLK and ser_dat_o equals PARK_DAT.
- R2: A start_i pulse while idle drives reconf_no low for exactly max(LOW_CYC, ACK_CYC) cycles, and never for fewer than LOW_CYC cycles.
- R3: Status and done must both be seen low within ACK_CYC cycles of reconf_no falling, counted on synchronized samples. Otherwise, at the end of the low pulse, the block goes idle with err_code_o = 1.
- R4: The synchronized status low time must lie in [STAT_MIN, STAT_MAX] cycles. Fewer gives err_code_o = 2, and more than STAT_MAX gives err_code_o = 3. No rising ser_clk_o edge occurs before status has returned high.
- R5: Each byte goes out least significant bit first, one bit per ser_clk_o rising edge. ser_dat_o changes only while ser_clk_o is low, and each clock phase lasts CLK_DIV cycles.
- R6: in_ready_o is 1 only while loading, with the shift register empty and the byte flagged in_last_i not yet accepted.
- R7: Status going low during loading or during the extra clocks aborts the run, returns the block to idle and sets err_code_o = 4.
- R8: Done seen high during loading or during the extra clocks ends the run with done_o = 1 and err_code_o = 0. After that the serial pins return to their park levels.
- R9: After the last byte, exactly TAIL_CLKS extra clocks are sent with ser_dat_o = PARK_DAT. If done is still low after them, the block goes idle with err_code_o = 5.
- R10: start_i is ignored while busy_o is 1.
- R11: An accepted start clears done_o and err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a configuration run |
| in_valid_i | input | 1 | Byte stream valid |
| in_data_i | input | DATA_W | Byte stream data |
| in_last_i | input | 1 | Marks the final byte of the stream |
| in_ready_o | output | 1 | Byte stream ready |
| tgt_stat_ni | input | 1 | Target status, active low |
| tgt_done_i | input | 1 | Target done |
| reconf_no | output | 1 | Reconfiguration request to target, active low |
| ser_clk_o | output | 1 | Serial configuration clock |
| ser_dat_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed |
| err_o | output | 1 | Last run failed |
| err_code_o | output | 3 | Failure cause (codes in R3, R4, R7, R9) |

## Verification
The hardest cases to reach are the status window edges: low times of exactly STAT_MIN and STAT_MAX must pass, while one cycle beyond STAT_MAX must fail. The bench target model drives status low for a programmed number of whole system clock cycles, aligned to the clock. The synchronizer delays both edges equally, so the counted low time equals the programmed one. The status drop in mid-load is triggered from the model's own count of observed serial clock rises, and so is the done rise, which lands at a chosen bit.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_TAIL  = 3'd4
  } seq_st_e;

  typedef enum logic [2:0] {
    E_NONE  = 3'd0,
    E_NOACK = 3'd1,
    E_SHORT = 3'd2,
    E_LONG  = 3'd3,
    E_DROP  = 3'd4,
    E_TMO   = 3'd5
  } err_e;
endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RST_VAL;
        else         r_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= {STAGES{RST_VAL}};
        else         r_q <= {r_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/ps_cfg_tx.sv
module ps_cfg_tx #(
  parameter int   DATA_W   = 8,
  parameter int   CLK_DIV  = 4,
  parameter logic PARK_CLK = 1'b0,
  parameter logic PARK_DAT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tail_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              rise_o,
  output logic              empty_o,
  output logic              last_done_o
);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int DCW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DATA_W-1:0] sh_q, sh_nx;
  logic [BW-1:0]     bits_q;
  logic [DCW-1:0]    div_q;
  logic              hi_q, full_q, last_q, got_last_q, clk_q, dat_q;
  logic              accept, tick;

  assign sh_nx       = sh_q >> 1;
  assign in_ready_o  = en_i & ~full_q & ~got_last_q & ~tail_i;
  assign accept      = in_valid_i & in_ready_o;
  assign tick        = full_q & (div_q == DCW'(CLK_DIV - 1));
  assign rise_o      = tick & ~hi_q;
  assign last_done_o = tick & hi_q & last_q & (bits_q == BW'(1));
  assign empty_o     = ~full_q;
  assign ser_clk_o   = clk_q;
  assign ser_dat_o   = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bits_q     <= '0;
      div_q      <= '0;
      hi_q       <= 1'b0;
      full_q     <= 1'b0;
      last_q     <= 1'b0;
      got_last_q <= 1'b0;
      clk_q      <= PARK_CLK;
      dat_q      <= PARK_DAT;
    end else if (!en_i) begin
      full_q     <= 1'b0;
      last_q     <= 1'b0;
      got_last_q <= 1'b0;
      hi_q       <= 1'b0;
      div_q      <= '0;
      clk_q      <= PARK_CLK;
      dat_q      <= PARK_DAT;
    end else if (accept) begin
      sh_q       <= in_data_i;
      bits_q     <= BW'(DATA_W);
      full_q     <= 1'b1;
      last_q     <= in_last_i;
      got_last_q <= in_last_i;
      hi_q       <= 1'b0;
      div_q      <= '0;
      clk_q      <= 1'b0;
      dat_q      <= in_data_i[0];
    end else if (!full_q && tail_i) begin
      // one filler bit per load
      bits_q <= BW'(1);
      full_q <= 1'b1;
      last_q <= 1'b0;
      hi_q   <= 1'b0;
      div_q  <= '0;
      clk_q  <= 1'b0;
      dat_q  <= PARK_DAT;
    end else if (full_q) begin
      if (tick) begin
        div_q <= '0;
        if (!hi_q) begin
          clk_q <= 1'b1;
          hi_q  <= 1'b1;
        end else begin
          clk_q <= 1'b0;
          hi_q  <= 1'b0;
          if (bits_q == BW'(1)) begin
            full_q <= 1'b0;
          end else begin
            sh_q   <= sh_nx;
            dat_q  <= sh_nx[0];
            bits_q <= bits_q - BW'(1);
          end
        end
      end else begin
        div_q <= div_q + DCW'(1);
      end
    end else begin
      clk_q <= 1'b0;
    end
  end

  // R5: data is settled before every rising clock edge
  p_dat_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> $stable(dat_q));

  // R5: no rise straight out of a new load
  p_load_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && accept) |=> !clk_q);
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int LOW_CYC   = 50,
  parameter int ACK_CYC   = 52,
  parameter int STAT_MIN  = 4500,
  parameter int STAT_MAX  = 23000,
  parameter int TAIL_CLKS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stat_i,
  input  logic       done_i,
  input  logic       tx_rise_i,
  input  logic       tx_empty_i,
  input  logic       tx_last_done_i,
  output logic       reconf_no,
  output logic       tx_en_o,
  output logic       tx_tail_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [2:0] err_code_o
);
  localparam int LOW_END = (LOW_CYC > ACK_CYC) ? LOW_CYC : ACK_CYC;
  localparam int CW      = $clog2(LOW_END + 1);
  localparam int SW      = $clog2(STAT_MAX + 2);
  localparam int TW      = $clog2(TAIL_CLKS + 2);

  seq_st_e       st_q;
  err_e          err_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] st_cnt_q;
  logic [TW-1:0] tail_q;
  logic          seen_s_q, seen_d_q, late_q, reconf_q, done_q;
  logic          ack_ok;

  assign ack_ok     = (seen_s_q | ~stat_i) & (seen_d_q | ~done_i);
  assign tx_en_o    = (st_q == ST_LOAD) || (st_q == ST_TAIL);
  assign tx_tail_o  = (st_q == ST_TAIL) && (tail_q < TW'(TAIL_CLKS));
  assign busy_o     = (st_q != ST_IDLE);
  assign reconf_no  = reconf_q;
  assign done_o     = done_q;
  assign err_o      = (err_q != E_NONE);
  assign err_code_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      err_q    <= E_NONE;
      cnt_q    <= '0;
      st_cnt_q <= '0;
      tail_q   <= '0;
      seen_s_q <= 1'b0;
      seen_d_q <= 1'b0;
      late_q   <= 1'b0;
      reconf_q <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q     <= ST_PULSE;
            reconf_q <= 1'b0;
            cnt_q    <= '0;
            st_cnt_q <= '0;
            seen_s_q <= 1'b0;
            seen_d_q <= 1'b0;
            late_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= E_NONE;
          end
        end
        ST_PULSE: begin
          cnt_q <= cnt_q + CW'(1);
          if (!stat_i) begin
            seen_s_q <= 1'b1;
            st_cnt_q <= st_cnt_q + SW'(1);
          end
          if (!done_i) seen_d_q <= 1'b1;
          if (cnt_q == CW'(ACK_CYC - 1) && !ack_ok) late_q <= 1'b1;
          // pulse always runs its full length, even on a missing answer
          if (cnt_q == CW'(LOW_END - 1)) begin
            reconf_q <= 1'b1;
            if (late_q || (cnt_q == CW'(ACK_CYC - 1) && !ack_ok)) begin
              st_q  <= ST_IDLE;
              err_q <= E_NOACK;
            end else begin
              st_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (stat_i) begin
            if (st_cnt_q < SW'(STAT_MIN)) begin
              st_q  <= ST_IDLE;
              err_q <= E_SHORT;
            end else begin
              st_q <= ST_LOAD;
            end
          end else if (st_cnt_q >= SW'(STAT_MAX)) begin
            st_q  <= ST_IDLE;
            err_q <= E_LONG;
          end else begin
            st_cnt_q <= st_cnt_q + SW'(1);
          end
        end
        ST_LOAD: begin
          if (!stat_i) begin
            st_q  <= ST_IDLE;
            err_q <= E_DROP;
          end else if (done_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (tx_last_done_i) begin
            st_q   <= ST_TAIL;
            tail_q <= '0;
          end
        end
        ST_TAIL: begin
          if (!stat_i) begin
            st_q  <= ST_IDLE;
            err_q <= E_DROP;
          end else if (done_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            if (tx_rise_i) tail_q <= tail_q + TW'(1);
            if (tail_q >= TW'(TAIL_CLKS) && tx_empty_i && !tx_rise_i) begin
              st_q  <= ST_IDLE;
              err_q <= E_TMO;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // independent count of request-low cycles
  logic [CW-1:0] mon_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           mon_low_q <= '0;
    else if (reconf_q)                     mon_low_q <= '0;
    else if (mon_low_q < CW'(LOW_END))     mon_low_q <= mon_low_q + CW'(1);
  end

  p_low_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reconf_no) |-> (mon_low_q >= CW'(LOW_CYC)));

  p_err_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);

  p_flags_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reconf_no && start_i) |=> reconf_no);

  p_start_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (!done_o && !err_o));
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host #(
  parameter int   DATA_W      = 8,
  parameter int   CLK_DIV     = 4,
  parameter int   LOW_CYC     = 50,
  parameter int   ACK_CYC     = 52,
  parameter int   STAT_MIN    = 4500,
  parameter int   STAT_MAX    = 23000,
  parameter int   TAIL_CLKS   = 64,
  parameter int   SYNC_STAGES = 2,
  parameter logic PARK_CLK    = 1'b0,
  parameter logic PARK_DAT    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic              tgt_stat_ni,
  input  logic              tgt_done_i,
  output logic              reconf_no,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o
);
  logic stat_s, done_s;
  logic tx_en, tx_tail, tx_rise, tx_empty, tx_last_done;

  ps_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stat (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(tgt_stat_ni), .q_o(stat_s)
  );

  ps_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_done (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(tgt_done_i), .q_o(done_s)
  );

  ps_cfg_seq #(
    .LOW_CYC  (LOW_CYC),
    .ACK_CYC  (ACK_CYC),
    .STAT_MIN (STAT_MIN),
    .STAT_MAX (STAT_MAX),
    .TAIL_CLKS(TAIL_CLKS)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .stat_i        (stat_s),
    .done_i        (done_s),
    .tx_rise_i     (tx_rise),
    .tx_empty_i    (tx_empty),
    .tx_last_done_i(tx_last_done),
    .reconf_no     (reconf_no),
    .tx_en_o       (tx_en),
    .tx_tail_o     (tx_tail),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .err_code_o    (err_code_o)
  );

  ps_cfg_tx #(
    .DATA_W  (DATA_W),
    .CLK_DIV (CLK_DIV),
    .PARK_CLK(PARK_CLK),
    .PARK_DAT(PARK_DAT)
  ) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tx_en),
    .tail_i     (tx_tail),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_last_i  (in_last_i),
    .in_ready_o (in_ready_o),
    .ser_clk_o  (ser_clk_o),
    .ser_dat_o  (ser_dat_o),
    .rise_o     (tx_rise),
    .empty_o    (tx_empty),
    .last_done_o(tx_last_done)
  );

  p_ready_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (busy_o && reconf_no));

  p_clk_after_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_clk_o) |-> (busy_o && reconf_no));

  p_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ($past(busy_o) == 1'b0)) |-> (ser_clk_o == PARK_CLK && ser_dat_o == PARK_DAT));
endmodule

// File: tb/ps_cfg_host_test.sv
`timescale 1ns/1ps
module ps_cfg_host_test;
  localparam int DW   = 8;
  localparam int DIV  = 2;
  localparam int LOWC = 6;
  localparam int ACKC = 8;
  localparam int SMIN = 20;
  localparam int SMAX = 40;
  localparam int TAIL = 4;
  localparam int LEND = (LOWC > ACKC) ? LOWC : ACKC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic stat_n = 1'b1, done_in = 1'b1;
  logic in_ready, reconf_n, ser_clk, ser_dat, busy, done, err;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  ps_cfg_host #(
    .DATA_W(DW), .CLK_DIV(DIV), .LOW_CYC(LOWC), .ACK_CYC(ACKC),
    .STAT_MIN(SMIN), .STAT_MAX(SMAX), .TAIL_CLKS(TAIL), .SYNC_STAGES(2),
    .PARK_CLK(1'b0), .PARK_DAT(1'b1)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .tgt_stat_ni(stat_n), .tgt_done_i(done_in), .reconf_no(reconf_n),
    .ser_clk_o(ser_clk), .ser_dat_o(ser_dat), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(err_code)
  );

  int checks = 0, fails = 0;
  int t_ack = 2, t_stat = SMIN, drop_at = 0, done_at = 0;
  logic no_ack = 1'b0;
  logic [7:0] tx_bytes [0:15];
  int tx_n = 0;
  logic cap [0:255];
  int nbits = 0;
  logic prev = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // target model
  always begin
    @(negedge reconf_n);
    if (!no_ack) begin
      repeat (t_ack) @(posedge clk);
      #1; stat_n = 1'b0; done_in = 1'b0;
      repeat (t_stat) @(posedge clk);
      #1; stat_n = 1'b1;
      prev = 1'b0; nbits = 0;
      while (busy) begin
        @(posedge clk); #1;
        if (ser_clk && !prev) begin
          cap[nbits] = ser_dat;
          nbits++;
          if (nbits == drop_at) stat_n = 1'b0;
          if (nbits == done_at) done_in = 1'b1;
        end
        prev = ser_clk;
      end
      stat_n = 1'b1;
    end
  end

  // port monitors
  int low_w = 0, last_low = 0, neg_cnt = 0, bad_rise = 0;
  logic m_rc = 1'b1, m_clk = 1'b0;
  always @(negedge clk) begin
    if (!reconf_n) low_w <= low_w + 1;
    else if (low_w != 0) begin last_low <= low_w; low_w <= 0; end
    if (!reconf_n && m_rc) neg_cnt <= neg_cnt + 1;
    if (ser_clk && !m_clk && !stat_n && drop_at == 0) bad_rise <= bad_rise + 1;
    m_rc  <= reconf_n;
    m_clk <= ser_clk;
  end

  task automatic feed();
    for (int i = 0; i < tx_n; i++) begin
      in_valid = 1'b1; in_data = tx_bytes[i]; in_last = (i == tx_n - 1);
      do @(negedge clk); while (!in_ready && busy);
      if (!busy) break;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run(input logic poke);
    repeat (10) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk); #1;
    chk(!done && !err, "R11 flags cleared by start", {done, err}, 0);
    chk(!in_ready, "R6 no ready during request pulse", in_ready, 0);
    feed();
    if (poke && busy) begin
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    for (int g = 0; g < 5000 && busy; g++) @(posedge clk);
    repeat (4) @(posedge clk); #1;
  endtask

  function automatic logic exp_bit(input int k);
    return tx_bytes[k / 8][k % 8];
  endfunction

  task automatic t_reset();
    chk(reconf_n == 1'b1, "R1 request idle high", reconf_n, 1);
    chk(!busy, "R1 busy low", busy, 0);
    chk(!done && !err, "R1 flags low", {done, err}, 0);
    chk(ser_clk == 1'b0, "R1 clock parked", ser_clk, 0);
    chk(ser_dat == 1'b1, "R1 data parked", ser_dat, 1);
    chk(!in_ready, "R1 ready low", in_ready, 0);
  endtask

  task automatic t_normal();
    int bad, n0;
    no_ack = 0; t_stat = SMIN; drop_at = 0; done_at = 24;
    tx_bytes[0] = 8'hA5; tx_bytes[1] = 8'h3C; tx_bytes[2] = 8'h0F; tx_n = 3;
    n0 = neg_cnt;
    run(1'b1);
    chk(last_low == LEND, "R2 request low width", last_low, LEND);
    chk(bad_rise == 0, "R4 no clock while status low", bad_rise, 0);
    chk(nbits >= 24 && nbits <= 24 + TAIL, "R5 bit count", nbits, 24);
    bad = 0;
    for (int k = 0; k < 24; k++) if (cap[k] !== exp_bit(k)) bad++;
    chk(bad == 0, "R5 LSB-first data", bad, 0);
    chk(done && err_code == 3'd0, "R8 done, no error", {done, err_code}, 8);
    chk(ser_clk == 1'b0 && ser_dat == 1'b1, "R8 park after done", {ser_clk, ser_dat}, 1);
    chk(neg_cnt == n0 + 1, "R10 start ignored while busy", neg_cnt - n0, 1);
    chk(!in_ready, "R6 ready low after run", in_ready, 0);
  endtask

  task automatic t_stat_max();
    no_ack = 0; t_stat = SMAX; drop_at = 0; done_at = 8;
    tx_bytes[0] = 8'h81; tx_n = 1;
    run(1'b0);
    chk(done && err_code == 3'd0, "R4 status low exactly max accepted", err_code, 0);
    chk(cap[0] == 1'b1 && cap[7] == 1'b1 && cap[3] == 1'b0, "R5 single byte bits",
        {cap[0], cap[3], cap[7]}, 5);
  endtask

  task automatic t_noack();
    no_ack = 1;
    tx_n = 1;
    run(1'b0);
    chk(err_code == 3'd1, "R3 missing answer code", err_code, 1);
    chk(last_low == LEND, "R2 full pulse on missing answer", last_low, LEND);
    chk(reconf_n && !busy, "R3 back to idle", {reconf_n, busy}, 2);
    no_ack = 0;
  endtask

  task automatic t_stat_bad(input int len, input int code);
    t_stat = len; drop_at = 0; done_at = 0; tx_n = 1;
    run(1'b0);
    chk(err_code == 3'(code), "R4 status window error", err_code, code);
    chk(!busy && !done, "R4 idle after window error", {busy, done}, 0);
    repeat (SMAX + 10) @(posedge clk);
  endtask

  task automatic t_drop();
    t_stat = SMIN; drop_at = 5; done_at = 0;
    for (int i = 0; i < 4; i++) tx_bytes[i] = 8'(8'h11 * (i + 1));
    tx_n = 4;
    run(1'b0);
    chk(err_code == 3'd4, "R7 status drop code", err_code, 4);
    chk(!in_ready && !busy, "R7 idle, no ready", {in_ready, busy}, 0);
    chk(ser_clk == 1'b0 && ser_dat == 1'b1, "R7 pins parked", {ser_clk, ser_dat}, 1);
    drop_at = 0;
  endtask

  task automatic t_timeout();
    int bad;
    t_stat = SMIN; drop_at = 0; done_at = 0;
    tx_bytes[0] = 8'hF0; tx_bytes[1] = 8'h0E; tx_n = 2;
    run(1'b0);
    chk(err_code == 3'd5, "R9 timeout code", err_code, 5);
    chk(nbits == 16 + TAIL, "R9 extra clock count", nbits, 16 + TAIL);
    bad = 0;
    for (int k = 16; k < 16 + TAIL; k++) if (cap[k] !== 1'b1) bad++;
    chk(bad == 0, "R9 filler data level", bad, 0);
    bad = 0;
    for (int k = 0; k < 16; k++) if (cap[k] !== exp_bit(k)) bad++;
    chk(bad == 0, "R5 data before filler", bad, 0);
  endtask

  task automatic t_early();
    int bad;
    t_stat = SMIN + 3; drop_at = 0; done_at = 10;
    tx_bytes[0] = 8'h5A; tx_bytes[1] = 8'hC3; tx_bytes[2] = 8'h77; tx_n = 3;
    run(1'b0);
    chk(done && !err, "R8 early done ends run", {done, err}, 2);
    chk(nbits >= 10 && nbits <= 11, "R8 stops soon after done", nbits, 10);
    bad = 0;
    for (int k = 0; k < 10; k++) if (cap[k] !== exp_bit(k)) bad++;
    chk(bad == 0, "R5 bits before early done", bad, 0);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_normal();
    t_stat_max();
    t_noack();
    t_stat_bad(SMIN - 1, 2);
    t_stat_bad(SMAX + 1, 3);
    t_drop();
    t_timeout();
    t_early();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule